// File: doc/BRIEF.md
# Reset Cause Status Register

This block is the 16-bit register that records why a small microcontroller last restarted. Each restart source (trap conflict, illegal opcode or uninitialised pointer use, configuration mismatch, external pin, software reset instruction, watchdog timeout, brown-out and power-on) sends a one-cycle pulse. The block turns that pulse into a sticky flag. The flags survive every restart except power-on, so firmware can read after boot which events have happened and clear them when it has handled them. The same register also records sleep and idle entry, and it holds three control bits: software watchdog enable, software brown-out enable, and program-memory power during sleep.

Two configuration fuse inputs take priority over the software control bits. A set watchdog fuse holds the effective watchdog enable high. The two-bit brown-out fuse field chooses among three cases: brown-out detection off, software control through the register, or forced on. The block drives the effective watchdog enable and the effective brown-out enable. The register port is a plain single-cycle write strobe with a combinational read value; there is no stream interface and no back-pressure.

The reset input `por_n` is synchronous and active low and stands only for power-on. Resets from all other sources reach the block only as event pulses.

Top module: `rst_cause_reg`

## Requirements
- R1: While `por_n` is low, the register loads 0x0003, with flag bit 1 (brown-out) and bit 0 (power-on) set. When `fuse_bor_mode` is 2'b01 (software control), bit 13 also comes up set, which gives 0x2003.
- R2: Bits 12, 11 and 10 always read 0, and writing them has no effect.
- R3: An event pulse sets its flag on the next clock edge. The flag positions are: trap 15, illegal opcode 14, configuration mismatch 9, pin 7, software reset 6, watchdog timeout 4, sleep entry 3, idle entry 2, brown-out 1.
- R4: A flag that has been set stays set through later event pulses from other sources. Only a software write or a power-on reset clears it.
- R5: When `wr_en` is high, every flag bit and the bits 8 and 5 take the value of `wr_data` on the next edge. Writing a 1 to a flag only stores the 1; nothing else in the block changes.
- R6: If an event pulse and a write that clears the same flag arrive in the same cycle, the flag ends up set.
- R7: `wdt_enable` is high whenever `fuse_wdt_on` is 1, whatever the value of bit 5. When `fuse_wdt_on` is 0, `wdt_enable` follows bit 5.
- R8: The `fuse_bor_mode` codes are: 2'b00 brown-out off, 2'b01 software control, 2'b10 or 2'b11 forced on. Outside code 2'b01, bit 13 reads 0 and ignores writes. `bor_enable` is 0 in code 2'b00, follows bit 13 in code 2'b01, and is 1 in codes 2'b10 and 2'b11.
- R9: Bit 8 (program-memory power in sleep) holds the value written to it and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low |
| ev_trap | input | 1 | Trap conflict event pulse |
| ev_badop | input | 1 | Illegal opcode or uninitialised pointer event pulse |
| ev_cfg_mismatch | input | 1 | Configuration mismatch event pulse |
| ev_pin | input | 1 | External reset pin event pulse |
| ev_sw_reset | input | 1 | Software reset instruction event pulse |
| ev_wdt_timeout | input | 1 | Watchdog timeout event pulse |
| ev_brownout | input | 1 | Brown-out event pulse |
| sleep_enter | input | 1 | Sleep entry pulse |
| idle_enter | input | 1 | Idle entry pulse |
| fuse_wdt_on | input | 1 | Watchdog fuse; 1 forces the watchdog on |
| fuse_bor_mode | input | 2 | Brown-out fuse field |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Current register value |
| wdt_enable | output | 1 | Effective watchdog enable |
| bor_enable | output | 1 | Effective brown-out enable |

## Verification
The hardest case to reach is a hardware event and a software clear hitting the same flag in the same cycle, because that event and that write must line up on one edge. The bench drives both in a single cycle on purpose and then lets a pseudo-random phase draw events and writes from independent bit streams, so these collisions also happen on many flags at once. The other hard case is the fuse-dependent reset value of bit 13. To reach it, the bench changes `fuse_bor_mode` and then applies power-on again, and also changes the fuse after reset to show that the software bit is then forced to 0.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int RCS_W      = 16;
  localparam int NUM_FLAGS  = 10;
  localparam int POS_SWBOR  = 13;
  localparam int POS_PMSLP  = 8;
  localparam int POS_SWWDT  = 5;

  typedef enum logic [1:0] {
    BORM_OFF    = 2'b00,
    BORM_SW     = 2'b01,
    BORM_ON     = 2'b10,
    BORM_ON_ALT = 2'b11
  } bor_mode_e;

  // flag index -> register bit position
  function automatic int flag_pos(input int idx);
    case (idx)
      0: return 0;   // power-on
      1: return 1;   // brown-out
      2: return 2;   // idle entry
      3: return 3;   // sleep entry
      4: return 4;   // watchdog timeout
      5: return 6;   // software reset
      6: return 7;   // pin
      7: return 9;   // config mismatch
      8: return 14;  // illegal opcode
      default: return 15; // trap
    endcase
  endfunction
endpackage

// File: rtl/rcs_flag_bank.sv
module rcs_flag_bank #(
  parameter int N = 10,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [N-1:0] set_ev,
  input  logic         wr_en,
  input  logic [N-1:0] wr_val,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!por_n)         q[i] <= INIT[i];
      else if (set_ev[i]) q[i] <= 1'b1;       // hardware set wins
      else if (wr_en)     q[i] <= wr_val[i];
    end

    // R3: an event makes the flag read 1 on the next edge
    a_r3_event_sets: assert property (@(posedge clk) disable iff (!por_n)
      set_ev[i] |=> q[i]);
    // R6: a clearing write in the same cycle does not beat the event
    a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!por_n)
      (set_ev[i] && wr_en && !wr_val[i]) |=> q[i]);
    // R4: without an event or a write the flag holds
    a_r4_flag_holds: assert property (@(posedge clk) disable iff (!por_n)
      (!set_ev[i] && !wr_en) |=> $stable(q[i]));
  end
endmodule

// File: rtl/rcs_ctrl_bits.sv
module rcs_ctrl_bits
  import rcs_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  bor_mode_e bor_mode,
  input  logic      fuse_wdt_on,
  input  logic      wr_en,
  input  logic      wr_swwdt,
  input  logic      wr_swbor,
  input  logic      wr_pmslp,
  output logic      swwdt_q,
  output logic      swbor_rd,
  output logic      pmslp_q,
  output logic      wdt_enable,
  output logic      bor_enable
);
  logic swbor_q;
  logic sw_mode;

  assign sw_mode = (bor_mode == BORM_SW);

  always_ff @(posedge clk) begin
    if (!por_n) begin
      swwdt_q <= 1'b0;
      pmslp_q <= 1'b0;
      swbor_q <= sw_mode;
    end else begin
      if (wr_en) begin
        swwdt_q <= wr_swwdt;
        pmslp_q <= wr_pmslp;
      end
      if (!sw_mode)   swbor_q <= 1'b0;
      else if (wr_en) swbor_q <= wr_swbor;
    end
  end

  assign swbor_rd   = swbor_q & sw_mode;
  assign wdt_enable = fuse_wdt_on | swwdt_q;

  always_comb begin
    case (bor_mode)
      BORM_OFF: bor_enable = 1'b0;
      BORM_SW:  bor_enable = swbor_q;
      default:  bor_enable = 1'b1;
    endcase
  end

  // R7: a software enable write turns the watchdog on
  a_r7_sw_wdt_write: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_swwdt) |=> wdt_enable);
  // R8: under software control a set write turns brown-out on
  a_r8_sw_bor_write: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_swbor && sw_mode) |=> (!sw_mode || bor_enable));
  // R9: the sleep power bit holds when nothing is written
  a_r9_pmslp_holds: assert property (@(posedge clk) disable iff (!por_n)
    !wr_en |=> $stable(pmslp_q));
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcs_pkg::*;
#(
  parameter int REG_W = RCS_W
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ev_trap,
  input  logic             ev_badop,
  input  logic             ev_cfg_mismatch,
  input  logic             ev_pin,
  input  logic             ev_sw_reset,
  input  logic             ev_wdt_timeout,
  input  logic             ev_brownout,
  input  logic             sleep_enter,
  input  logic             idle_enter,
  input  logic             fuse_wdt_on,
  input  logic [1:0]       fuse_bor_mode,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             wdt_enable,
  output logic             bor_enable
);
  localparam int NF = NUM_FLAGS;
  localparam logic [NF-1:0] FLAG_INIT = NF'(2'b11);

  logic [NF-1:0] set_ev, wr_val, flags_q;
  logic swwdt_q, swbor_rd, pmslp_q;
  bor_mode_e bor_mode;

  assign bor_mode = bor_mode_e'(fuse_bor_mode);
  assign set_ev = {ev_trap, ev_badop, ev_cfg_mismatch, ev_pin, ev_sw_reset,
                   ev_wdt_timeout, sleep_enter, idle_enter, ev_brownout, 1'b0};

  for (genvar i = 0; i < NF; i++) begin : g_wr
    assign wr_val[i] = wr_data[flag_pos(i)];
  end

  rcs_flag_bank #(.N(NF), .INIT(FLAG_INIT)) u_flags (
    .clk   (clk),
    .por_n (por_n),
    .set_ev(set_ev),
    .wr_en (wr_en),
    .wr_val(wr_val),
    .q     (flags_q)
  );

  rcs_ctrl_bits u_ctrl (
    .clk        (clk),
    .por_n      (por_n),
    .bor_mode   (bor_mode),
    .fuse_wdt_on(fuse_wdt_on),
    .wr_en      (wr_en),
    .wr_swwdt   (wr_data[POS_SWWDT]),
    .wr_swbor   (wr_data[POS_SWBOR]),
    .wr_pmslp   (wr_data[POS_PMSLP]),
    .swwdt_q    (swwdt_q),
    .swbor_rd   (swbor_rd),
    .pmslp_q    (pmslp_q),
    .wdt_enable (wdt_enable),
    .bor_enable (bor_enable)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NF; i++) rd_data[flag_pos(i)] = flags_q[i];
    rd_data[POS_SWWDT] = swwdt_q;
    rd_data[POS_SWBOR] = swbor_rd;
    rd_data[POS_PMSLP] = pmslp_q;
  end

  // R1: power-on leaves the power-on and brown-out flags set
  a_r1_por_flags: assert property (@(posedge clk)
    !por_n |=> (rd_data[1:0] == 2'b11));
  // R5: a write of all zeros with no events clears the pin flag
  a_r5_write_clears: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_data == '0 && !ev_pin) |=> !rd_data[7]);
endmodule

// File: tb/rst_cause_reg_tb_top.sv
module rst_cause_reg_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic por_n, ev_trap, ev_badop, ev_cfg, ev_pin, ev_sw, ev_wdt, ev_bor;
  logic sleep_e, idle_e, fuse_wdt, wr_en;
  logic [1:0] fuse_bor;
  logic [15:0] wr_data, rd_data;
  logic wdt_enable, bor_enable;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  rst_cause_reg dut_i (
    .clk(clk), .por_n(por_n), .ev_trap(ev_trap), .ev_badop(ev_badop),
    .ev_cfg_mismatch(ev_cfg), .ev_pin(ev_pin), .ev_sw_reset(ev_sw),
    .ev_wdt_timeout(ev_wdt), .ev_brownout(ev_bor), .sleep_enter(sleep_e),
    .idle_enter(idle_e), .fuse_wdt_on(fuse_wdt), .fuse_bor_mode(fuse_bor),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .wdt_enable(wdt_enable), .bor_enable(bor_enable));

  // behavioural reference
  logic [15:0] m;
  logic sb;
  logic [15:0] exp_rd;
  logic exp_wdt, exp_bor;

  always @(posedge clk) begin
    cycles++;
    if (!por_n) begin
      m = 16'h0003;
      sb = (fuse_bor == 2'b01);
    end else begin
      if (wr_en) begin
        m = wr_data & 16'hC3FF;
        m[13] = 1'b0;
        if (fuse_bor == 2'b01) sb = wr_data[13];
      end
      if (fuse_bor != 2'b01) sb = 1'b0;
      m = m | {ev_trap, ev_badop, 4'b0, ev_cfg, 1'b0, ev_pin, ev_sw, 1'b0,
               ev_wdt, sleep_e, idle_e, ev_bor, 1'b0};
    end
    #2;
    exp_rd  = m | ((sb && fuse_bor == 2'b01) ? 16'h2000 : 16'h0000);
    exp_wdt = fuse_wdt | exp_rd[5];
    exp_bor = fuse_bor[1] ? 1'b1 : (fuse_bor == 2'b01) ? exp_rd[13] : 1'b0;
    checks++;
    if (rd_data !== exp_rd || wdt_enable !== exp_wdt || bor_enable !== exp_bor) begin
      errors++;
      $display("FAIL %s model: rd=%h wdt=%b bor=%b expected rd=%h wdt=%b bor=%b",
               cur_req, rd_data, wdt_enable, bor_enable, exp_rd, exp_wdt, exp_bor);
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_in();
    {ev_trap, ev_badop, ev_cfg, ev_pin, ev_sw, ev_wdt, ev_bor, sleep_e, idle_e, wr_en} = '0;
    wr_data = '0;
  endtask

  task automatic cyc(); @(negedge clk); clr_in(); endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d; @(negedge clk); clr_in();
  endtask

  task automatic por();
    @(negedge clk); por_n = 1'b0; @(negedge clk); @(negedge clk); por_n = 1'b1;
  endtask

  initial begin
    por_n = 1'b0; fuse_wdt = 1'b0; fuse_bor = 2'b00; clr_in();
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    chk("R1 reset value", rd_data, 16'h0003);
    chk("R1 enables", {14'b0, wdt_enable, bor_enable}, 16'h0000);

    cur_req = "R3";
    @(negedge clk); ev_trap = 1; cyc(); chk("R3 trap bit15", rd_data, 16'h8003);
    @(negedge clk); ev_badop = 1; cyc(); chk("R3 badop bit14", rd_data, 16'hC003);
    @(negedge clk); ev_cfg = 1; ev_pin = 1; cyc(); chk("R3 cfg/pin", rd_data, 16'hC283);
    @(negedge clk); ev_sw = 1; ev_wdt = 1; cyc(); chk("R3 sw/wdt", rd_data, 16'hC2D3);
    @(negedge clk); sleep_e = 1; idle_e = 1; cyc(); chk("R3 sleep/idle", rd_data, 16'hC2DF);

    cur_req = "R5";
    wr(16'h0000); chk("R5 clear all", rd_data, 16'h0000);
    cur_req = "R4";
    @(negedge clk); ev_pin = 1; cyc();
    @(negedge clk); ev_wdt = 1; cyc();
    @(negedge clk); ev_bor = 1; cyc();
    chk("R4 pin flag survives", rd_data, 16'h0092);
    repeat (3) cyc(); chk("R4 idle hold", rd_data, 16'h0092);

    cur_req = "R2";
    wr(16'hFFFF); chk("R2/R8 all-ones write", rd_data, 16'hC3FF);
    cur_req = "R7";
    chk("R7 sw wdt on", {15'b0, wdt_enable}, 16'h0001);
    cur_req = "R6";
    @(negedge clk); ev_trap = 1; wr_en = 1; wr_data = 16'h0000; cyc();
    chk("R6 set beats clear", rd_data, 16'h8000);

    cur_req = "R7";
    @(negedge clk); fuse_wdt = 1; cyc();
    chk("R7 fuse forces wdt", {15'b0, wdt_enable}, 16'h0001);
    chk("R7 sw bit untouched", rd_data, 16'h8000);
    @(negedge clk); fuse_wdt = 0; cyc();

    cur_req = "R9";
    wr(16'h0100); chk("R9 pm sleep set", rd_data, 16'h0100);
    wr(16'h0000); chk("R9 pm sleep clear", rd_data, 16'h0000);

    cur_req = "R8";
    @(negedge clk); fuse_bor = 2'b01; cyc();
    por(); chk("R8/R1 sw mode reset", rd_data, 16'h2003);
    chk("R8 sw mode enable", {15'b0, bor_enable}, 16'h0001);
    wr(16'h0000); chk("R8 sw clear", {rd_data[13], bor_enable}, 16'h0000);
    wr(16'h2000); chk("R8 sw set", {rd_data[13], bor_enable}, 16'h0003);
    @(negedge clk); fuse_bor = 2'b10; cyc();
    chk("R8 forced on reads 0", {rd_data[13], bor_enable}, 16'h0001);
    @(negedge clk); fuse_bor = 2'b00; cyc();
    wr(16'h2000); chk("R8 off ignores write", {rd_data[13], bor_enable}, 16'h0000);

    cur_req = "R6 random";
    fuse_bor = 2'b01;
    begin
      logic [31:0] lf = 32'hACE1_1234;
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        {ev_trap, ev_badop, ev_cfg, ev_pin, ev_sw, ev_wdt, ev_bor, sleep_e, idle_e} =
          lf[8:0] & lf[17:9] & lf[26:18];
        wr_en = lf[27] & lf[28];
        wr_data = lf[15:0] ^ lf[31:16];
        fuse_wdt = lf[29] & lf[30];
        if (k == 200) fuse_bor = 2'b11;
        if (k == 300) fuse_bor = 2'b01;
      end
    end
    cyc();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) if (cycles > 20000) begin
    errors++;
    $display("FAIL watchdog actual=%0d cycles expected=under 20000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule